// File: doc/BRIEF.md
# Ripple-Carry Integer ALU with Less-Than Compare

This block is a purely combinational integer arithmetic and logic unit of configurable width, 32 bits by default. It is a chain of identical one-bit cells. Each cell can present the AND or OR of its two operand bits, or a full-adder sum, and it passes its carry on to the next cell. Every cell has an input that can invert the A bit and an input that can invert the B bit, so the same cells also give NAND, NOR and subtraction.

A 4-bit operation code selects the operation. Bit 3 inverts A. Bit 2 inverts B and also supplies the carry into bit 0. Bits 1:0 choose what each cell outputs: 00 AND, 01 OR, 10 sum, 11 less. For a signed compare, the sign of A − B is corrected by the signed overflow of that subtraction. The corrected value is routed from the top cell back into bit 0; every other bit of the result is 0 for this operation.

Alongside the result, the block reports three flags: zero, signed overflow and unsigned overflow/borrow. The block has no clock and no storage. Data is applied to the inputs and read from the outputs directly, so there is no valid/ready handshake and no back-pressure to obey. A surrounding pipeline registers the outputs wherever it needs them.

Top module: `ripple_alu`

## Requirements
- R1: Code 0000 gives A AND B; code 0001 gives A OR B.
- R2: Code 1100 gives NOR(A,B), because A and B are both inverted and the cells select AND. Code 1101 gives NAND(A,B), because both are inverted and the cells select OR.
- R3: Code 0010 gives A + B modulo 2^WIDTH.
- R4: Code 0110 gives A − B modulo 2^WIDTH, computed as A + ~B + 1.
- R5: Code 0111 gives 1 in bit 0 exactly when signed A is less than signed B. This holds even when A − B overflows. All higher bits are 0.
- R6: For code 0010, signed overflow is 1 exactly when A and B have the same sign and the sum's sign differs from it.
- R7: For code 0110, signed overflow is 1 exactly when A and B differ in sign and the difference's sign differs from A's sign.
- R8: The unsigned flag equals the carry out of the top bit for code 0010, and equals the borrow (A < B unsigned) for code 0110.
- R9: The zero flag is 1 exactly when every result bit is 0, for every operation code.
- R10: Both overflow flags are 0 for the logic codes (0000, 0001, 1100, 1101) and for the compare code 0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code: [3] invert A, [2] invert B and carry in, [1:0] cell output select |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | All result bits are 0 |
| ovf_s_o | output | 1 | Signed overflow of add or subtract |
| ovf_u_o | output | 1 | Carry out on add, borrow on subtract |

## Verification
Random operands are drawn both uniformly and from a pool of corner values: 0, 1, all ones, the most positive value and the most negative value. Drawing from the pool makes carries that run the full chain and signed overflows common rather than rare. The most positive and most negative values, added and subtracted in both orders, separate the signed flag from the unsigned flag. The same pairs under the compare code separate a compare that trusts the raw sign from one that corrects it with overflow. Equal operands under subtract and compare show whether the zero flag and the strict less-than both respond, while the all-ones plus one case shows a carry out that comes together with a zero result.

// File: rtl/ripple_alu_pkg.sv
package ripple_alu_pkg;
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } cell_sel_e;

  localparam int OP_W = 4;
  localparam int OP_AINV_BIT = 3;
  localparam int OP_BNEG_BIT = 2;
endpackage

// File: rtl/ripple_alu_slice.sv
module ripple_alu_slice
  import ripple_alu_pkg::*;
(
  input  logic      a_i,
  input  logic      b_i,
  input  logic      a_inv_i,
  input  logic      b_neg_i,
  input  logic      carry_i,
  input  logic      less_i,
  input  cell_sel_e sel_i,
  output logic      result_o,
  output logic      carry_o
);
  logic a_eff, b_eff, sum_bit;

  assign a_eff   = a_i ^ a_inv_i;
  assign b_eff   = b_i ^ b_neg_i;
  assign sum_bit = a_eff ^ b_eff ^ carry_i;
  assign carry_o = (a_eff & b_eff) | (carry_i & (a_eff ^ b_eff));

  always_comb begin
    unique case (sel_i)
      SEL_AND:  result_o = a_eff & b_eff;
      SEL_OR:   result_o = a_eff | b_eff;
      SEL_SUM:  result_o = sum_bit;
      default:  result_o = less_i;
    endcase
  end
endmodule

// File: rtl/ripple_alu_flags.sv
module ripple_alu_flags
  import ripple_alu_pkg::*;
(
  input  logic      a_top_i,
  input  logic      b_top_i,
  input  logic      a_inv_i,
  input  logic      b_neg_i,
  input  logic      carry_into_top_i,
  input  logic      carry_out_top_i,
  input  cell_sel_e sel_i,
  output logic      set_o,
  output logic      ovf_s_o,
  output logic      ovf_u_o
);
  logic top_sign, raw_ovf, is_arith;

  assign top_sign = (a_top_i ^ a_inv_i) ^ (b_top_i ^ b_neg_i) ^ carry_into_top_i;
  assign raw_ovf  = carry_into_top_i ^ carry_out_top_i;
  assign set_o    = top_sign ^ raw_ovf;
  assign is_arith = (sel_i == SEL_SUM);
  assign ovf_s_o  = is_arith & raw_ovf;
  assign ovf_u_o  = is_arith & (carry_out_top_i ^ b_neg_i);
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
  import ripple_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_s_o,
  output logic             ovf_u_o
);
  localparam int MSB = WIDTH - 1;

  cell_sel_e sel;
  logic      a_inv, b_neg;
  logic      set_bit;

  assign sel   = cell_sel_e'(op_i[1:0]);
  assign a_inv = op_i[OP_AINV_BIT];
  assign b_neg = op_i[OP_BNEG_BIT];

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic cin, cout, less_in;
    if (i == 0) begin : g_first
      assign cin     = b_neg;
      assign less_in = set_bit;
    end else begin : g_rest
      assign cin     = g_bit[i-1].cout;
      assign less_in = 1'b0;
    end
    ripple_alu_slice u_slice (
      .a_i      (a_i[i]),
      .b_i      (b_i[i]),
      .a_inv_i  (a_inv),
      .b_neg_i  (b_neg),
      .carry_i  (cin),
      .less_i   (less_in),
      .sel_i    (sel),
      .result_o (result_o[i]),
      .carry_o  (cout)
    );
  end

  ripple_alu_flags u_flags (
    .a_top_i          (a_i[MSB]),
    .b_top_i          (b_i[MSB]),
    .a_inv_i          (a_inv),
    .b_neg_i          (b_neg),
    .carry_into_top_i (g_bit[MSB].cin),
    .carry_out_top_i  (g_bit[MSB].cout),
    .sel_i            (sel),
    .set_o            (set_bit),
    .ovf_s_o          (ovf_s_o),
    .ovf_u_o          (ovf_u_o)
  );

  assign zero_o = ~|result_o;
endmodule

// File: rtl/ripple_alu_checker.sv
module ripple_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_s_o,
  input logic             ovf_u_o
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH:0] add_w, sub_w;
  logic           known;

  always_comb begin
    add_w = {1'b0, a_i} + {1'b0, b_i};
    sub_w = {1'b0, a_i} - {1'b0, b_i};
    known = !$isunknown({op_i, a_i, b_i, result_o, zero_o, ovf_s_o, ovf_u_o});
    if (known) begin
      assert_zero_flag_R9: assert (zero_o == (result_o == '0))
        else $error("zero flag disagrees with result");
      if (op_i == 4'b0010) begin
        assert_add_sum_R3: assert (result_o == add_w[MSB:0])
          else $error("add result wrong");
        assert_add_sovf_R6: assert (ovf_s_o == ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
          else $error("add signed overflow wrong");
        assert_add_carry_R8: assert (ovf_u_o == add_w[WIDTH])
          else $error("add carry wrong");
      end
      if (op_i == 4'b0110) begin
        assert_sub_diff_R4: assert (result_o == sub_w[MSB:0])
          else $error("sub result wrong");
        assert_sub_sovf_R7: assert (ovf_s_o == ((a_i[MSB] != b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
          else $error("sub signed overflow wrong");
        assert_sub_borrow_R8: assert (ovf_u_o == (a_i < b_i))
          else $error("sub borrow wrong");
      end
      if (op_i == 4'b0111) begin
        assert_slt_value_R5: assert (result_o == {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
          else $error("set-less-than wrong");
      end
      if (op_i[1:0] != 2'b10) begin
        assert_no_overflow_R10: assert (!ovf_s_o && !ovf_u_o)
          else $error("overflow flag on non-arith op");
      end
      if (op_i == 4'b1100) begin
        assert_nor_R2: assert (result_o == ~(a_i | b_i)) else $error("nor wrong");
      end
      if (op_i == 4'b0000) begin
        assert_and_R1: assert (result_o == (a_i & b_i)) else $error("and wrong");
      end
    end
  end
endmodule

bind ripple_alu ripple_alu_checker #(.WIDTH(WIDTH)) u_checker (
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .ovf_s_o  (ovf_s_o),
  .ovf_u_o  (ovf_u_o)
);

// File: tb/ripple_alu_bench.sv
module ripple_alu_bench;
  localparam int W = 32;
  localparam logic [3:0] OP_AND = 4'b0000, OP_OR = 4'b0001, OP_ADD = 4'b0010,
                         OP_SUB = 4'b0110, OP_SLT = 4'b0111, OP_NOR = 4'b1100,
                         OP_NAND = 4'b1101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]   op;
  logic [W-1:0] a, b, res;
  logic         zero, ovf_s, ovf_u;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ripple_alu #(.WIDTH(W)) u_ripple_alu (
    .op_i(op), .a_i(a), .b_i(b), .result_o(res),
    .zero_o(zero), .ovf_s_o(ovf_s), .ovf_u_o(ovf_u)
  );

  function automatic logic [W-1:0] exp_res(logic [3:0] o, logic [W-1:0] x, logic [W-1:0] y);
    case (o)
      OP_AND:  return x & y;
      OP_OR:   return x | y;
      OP_ADD:  return x + y;
      OP_SUB:  return x - y;
      OP_SLT:  return ($signed(x) < $signed(y)) ? W'(1) : W'(0);
      OP_NOR:  return ~(x | y);
      default: return ~(x & y);
    endcase
  endfunction

  function automatic logic exp_ovs(logic [3:0] o, logic [W-1:0] x, logic [W-1:0] y);
    logic [W-1:0] s;
    if (o == OP_ADD) begin
      s = x + y;
      return (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
    end
    if (o == OP_SUB) begin
      s = x - y;
      return (x[W-1] != y[W-1]) && (s[W-1] != x[W-1]);
    end
    return 1'b0;
  endfunction

  function automatic logic exp_ovu(logic [3:0] o, logic [W-1:0] x, logic [W-1:0] y);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (o == OP_ADD) return s[W];
    if (o == OP_SUB) return x < y;
    return 1'b0;
  endfunction

  function automatic string tag_of(logic [3:0] o);
    case (o)
      OP_AND, OP_OR:   return "R1";
      OP_NOR, OP_NAND: return "R2";
      OP_ADD:          return "R3";
      OP_SUB:          return "R4";
      default:         return "R5";
    endcase
  endfunction

  task automatic chk(string tag, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, a, b, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] o, logic [W-1:0] x, logic [W-1:0] y);
    logic [W-1:0] e;
    logic         ovs_tag_add;
    @(posedge clk);
    #1;
    op = o; a = x; b = y;
    @(negedge clk);
    e = exp_res(o, x, y);
    ovs_tag_add = (o == OP_ADD);
    chk(tag_of(o), {1'b0, res}, {1'b0, e});
    chk("R9", {{W{1'b0}}, zero}, {{W{1'b0}}, (e == '0)});
    if (o == OP_ADD || o == OP_SUB) begin
      chk(ovs_tag_add ? "R6" : "R7", {{W{1'b0}}, ovf_s}, {{W{1'b0}}, exp_ovs(o, x, y)});
      chk("R8", {{W{1'b0}}, ovf_u}, {{W{1'b0}}, exp_ovu(o, x, y)});
    end else begin
      chk("R10", {{(W-1){1'b0}}, ovf_s, ovf_u}, '0);
    end
  endtask

  function automatic logic [W-1:0] pick(int unsigned r);
    case (r % 8)
      0: return '0;
      1: return W'(1);
      2: return '1;
      3: return {1'b0, {(W-1){1'b1}}};
      4: return {1'b1, {(W-1){1'b0}}};
      default: return W'($urandom);
    endcase
  endfunction

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] ops [7];
    ops = '{OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR, OP_NAND};
    void'($urandom(32'd1234));
    op = OP_AND; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: zero inputs, AND -> result 0, zero flag set (R9)
    chk("R9", {1'b0, res}, '0);
    chk("R9", {{W{1'b0}}, zero}, {{W{1'b0}}, 1'b1});
    // directed corners
    apply(OP_ADD, 32'h7fffffff, 32'h1);          // R6 signed overflow
    apply(OP_ADD, 32'hffffffff, 32'h1);          // R8 carry, R9 zero
    apply(OP_ADD, 32'h80000000, 32'h80000000);   // R6 negative overflow
    apply(OP_ADD, 32'h7fffffff, 32'h80000000);   // R6 mixed signs, none
    apply(OP_SUB, 32'h80000000, 32'h1);          // R7 overflow
    apply(OP_SUB, 32'h0, 32'h1);                 // R8 borrow
    apply(OP_SUB, 32'h1234, 32'h1234);           // R9 zero on equal
    apply(OP_SUB, 32'h7fffffff, 32'hffffffff);   // R7 overflow other way
    apply(OP_SLT, 32'h80000000, 32'h7fffffff);   // R5 overflowing compare, less
    apply(OP_SLT, 32'h7fffffff, 32'h80000000);   // R5 not less
    apply(OP_SLT, 32'h55, 32'h55);               // R5 equal
    apply(OP_SLT, 32'hfffffffe, 32'hffffffff);   // R5 negative
    apply(OP_NOR, 32'h0, 32'h0);                 // R2
    apply(OP_NAND, 32'hffffffff, 32'hffffffff);  // R2 zero result
    apply(OP_AND, 32'hf0f0f0f0, 32'hff00ff00);   // R1
    apply(OP_OR, 32'hf0f0f0f0, 32'h0f0f0f0f);    // R1
    for (int n = 0; n < 1500; n++) begin
      int unsigned r;
      r = $urandom;
      apply(ops[r % 7], pick($urandom), pick($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule